// File: doc/BRIEF.md
# Digital Reference Slew Ramp Generator

This block produces the set-point for a core-voltage regulator as a number that moves toward a commanded level at a controlled speed. A 4-bit target code selects a level between 850 mV and 1600 mV in 50 mV steps. A 2-bit slew code selects one of four ramp speeds. An internal accumulator holds the reference with microvolt resolution. On every clock it moves the reference one step toward the target and never passes it. The reported reference is that accumulator truncated to whole millivolts.

When enable rises, the reference climbs from zero at a fixed start-up speed, whatever the slew code says. Once it has reached the target for the first time, each later change of target, up or down, is followed at the programmed speed. A strap input selects a static mode in which every move uses the start-up speed. When enable drops, the reference collapses to zero but the target keeps tracking its input. The next enable therefore ramps straight to the current target. A settled flag marks the cycles in which the reference sits exactly on the target.

Top module: `slew_ramp_top`

## Requirements
- R1: The target in millivolts is 850 + 50 × tgtCode, for tgtCode 0 to 15. When settled, refMv equals this value.
- R2: slewCode 2'b00, 2'b01, 2'b10 and 2'b11 select 0.5, 1, 2.5 and 5 mV/µs. The per-clock step is BASE_STEP_UV × 1, 2, 5 and 10 µV, where BASE_STEP_UV is the step for 0.5 mV/µs at the clock rate in use. A new tgtCode, slewCode or pinMode is registered on the first clock edge and steers the reference from the second edge on.
- R3: After enable rises, the reference starts from 0 and climbs at the start-up step (the 2'b01 step, 1 mV/µs) until it first reaches the target. The slew code has no effect during this climb.
- R4: After the start-up climb, every change of target is followed at the programmed step, in both the rising and the falling direction.
- R5: While pinMode is 1, every move uses the start-up step, whatever slewCode holds.
- R6: The reference never passes the target. When the remaining gap is no larger than one step, the next edge lands exactly on the target.
- R7: One edge after enable is sampled low, refMv is 0 and settled is 0. Both stay so while enable is low.
- R8: tgtCode is still registered while enable is low. On re-enable the reference climbs from 0 to the most recent target at the start-up step.
- R9: settled is 1 only while enabled and with the reference exactly equal to the target. A move that needs N steps therefore raises settled N + 1 edges after the new inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset (power-on release) |
| enable | input | 1 | Run request; low forces the reference to zero |
| pinMode | input | 1 | 1 = static mode, every move at start-up speed |
| tgtCode | input | CODE_W (4) | Target voltage code |
| slewCode | input | 2 | Ramp speed select |
| refMv | output | MV_W (11) | Reference value in whole millivolts |
| settled | output | 1 | Reference equals target while enabled |

## Verification
The bench builds the block with BASE_STEP_UV = 300 instead of the default. That scales every ramp about six times shorter, so full climbs from zero, full-range descents and re-enable cycles each complete in a few thousand clocks. Because 300 µV steps do not divide 50 mV moves evenly, the final clamped step (R6) occurs on almost every move. The exact settle cycle counts then tell the four programmed speeds and the start-up speed apart.

// File: rtl/slew_ramp_pkg.sv
package slew_ramp_pkg;

  localparam int unsigned SLEW_W    = 2;
  localparam int unsigned NUM_RATES = 1 << SLEW_W;
  localparam logic [SLEW_W-1:0] RATE_STARTUP = 2'b01;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_START = 2'd1,
    ST_RUN   = 2'd2
  } rampState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              clear;    // force reference to zero
    logic [SLEW_W-1:0] rateSel;  // which step size to apply
  } rampStrobe_t;

  // speed multiple of the slowest rate: 0.5, 1, 2.5, 5 mV/us
  function automatic int unsigned rateMult(input int unsigned sel);
    case (sel)
      0:       return 1;
      1:       return 2;
      2:       return 5;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/slew_ramp_ctrl.sv
module slew_ramp_ctrl
  import slew_ramp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              pinMode,
  input  logic [SLEW_W-1:0] slewCode,
  input  logic              atTarget,
  output rampStrobe_t       strobe,
  output logic              active
);

  rampState_e        stateQ, stateD;
  logic [SLEW_W-1:0] slewQ;
  logic              pinQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slewQ <= RATE_STARTUP;
      pinQ  <= 1'b0;
    end else begin
      slewQ <= slewCode;
      pinQ  <= pinMode;
    end
  end

  always_comb begin
    stateD = stateQ;
    if (!enable) begin
      stateD = ST_OFF;
    end else begin
      case (stateQ)
        ST_OFF:   stateD = ST_START;
        ST_START: if (atTarget) stateD = ST_RUN;
        ST_RUN:   stateD = ST_RUN;
        default:  stateD = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_OFF;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.clear   = !enable || (stateQ == ST_OFF);
    strobe.rateSel = ((stateQ == ST_START) || pinQ) ? RATE_STARTUP : slewQ;
  end

  assign active = enable && (stateQ != ST_OFF);

  AST_START_FROM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_OFF && enable) |=> (stateQ == ST_START)); // R3

  AST_OFF_WHEN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (stateQ == ST_OFF && !active)); // R7

endmodule

// File: rtl/slew_ramp_dp.sv
module slew_ramp_dp
  import slew_ramp_pkg::*;
#(
  parameter int unsigned CODE_W       = 4,
  parameter int unsigned BASE_MV      = 850,
  parameter int unsigned STEP_MV      = 50,
  parameter int unsigned BASE_STEP_UV = 50,
  parameter int unsigned UV_W         = 21,
  parameter int unsigned MV_W         = 11
)(
  input  logic              clk,
  input  logic              rstN,
  input  rampStrobe_t       strobe,
  input  logic [CODE_W-1:0] tgtCode,
  output logic              atTarget,
  output logic [MV_W-1:0]   refMv
);

  localparam int unsigned UV_PER_MV = 1000;
  localparam int unsigned MAX_STEP  = BASE_STEP_UV * rateMult(NUM_RATES - 1);

  logic [CODE_W-1:0] tgtQ;
  logic [UV_W-1:0]   tgtUv, refUvQ, refUvD, gapUv, stepUv;
  logic [UV_W-1:0]   stepTab [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_step
    assign stepTab[g] = UV_W'(BASE_STEP_UV * rateMult(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tgtQ <= '0;
    else       tgtQ <= tgtCode;
  end

  assign tgtUv  = UV_W'(BASE_MV * UV_PER_MV) + UV_W'(STEP_MV * UV_PER_MV) * UV_W'(tgtQ);
  assign stepUv = stepTab[strobe.rateSel];
  assign gapUv  = (refUvQ < tgtUv) ? (tgtUv - refUvQ) : (refUvQ - tgtUv);

  always_comb begin
    if (strobe.clear)         refUvD = '0;
    else if (gapUv <= stepUv) refUvD = tgtUv;
    else if (refUvQ < tgtUv)  refUvD = refUvQ + stepUv;
    else                      refUvD = refUvQ - stepUv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refUvQ <= '0;
    else       refUvQ <= refUvD;
  end

  assign atTarget = (refUvQ == tgtUv);
  assign refMv    = MV_W'(refUvQ / UV_W'(UV_PER_MV));

  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && refUvQ <= tgtUv) |=> (refUvQ <= $past(tgtUv))); // R6

  AST_NO_UNDERSHOOT: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && refUvQ >= tgtUv) |=> (refUvQ >= $past(tgtUv))); // R6

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> ((refUvQ >= $past(refUvQ)) ?
      ((refUvQ - $past(refUvQ)) <= UV_W'(MAX_STEP)) :
      (($past(refUvQ) - refUvQ) <= UV_W'(MAX_STEP)))); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (refUvQ == '0)); // R7

endmodule

// File: rtl/slew_ramp_top.sv
module slew_ramp_top
  import slew_ramp_pkg::*;
#(
  parameter int unsigned CODE_W       = 4,
  parameter int unsigned BASE_MV      = 850,
  parameter int unsigned STEP_MV      = 50,
  parameter int unsigned BASE_STEP_UV = 50,
  localparam int unsigned MAX_MV = BASE_MV + STEP_MV * ((1 << CODE_W) - 1),
  localparam int unsigned UV_W   = $clog2(MAX_MV * 1000 + 1),
  localparam int unsigned MV_W   = $clog2(MAX_MV + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              pinMode,
  input  logic [CODE_W-1:0] tgtCode,
  input  logic [SLEW_W-1:0] slewCode,
  output logic [MV_W-1:0]   refMv,
  output logic              settled
);

  rampStrobe_t strobe;
  logic        atTarget;
  logic        active;

  slew_ramp_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .pinMode  (pinMode),
    .slewCode (slewCode),
    .atTarget (atTarget),
    .strobe   (strobe),
    .active   (active)
  );

  slew_ramp_dp #(
    .CODE_W       (CODE_W),
    .BASE_MV      (BASE_MV),
    .STEP_MV      (STEP_MV),
    .BASE_STEP_UV (BASE_STEP_UV),
    .UV_W         (UV_W),
    .MV_W         (MV_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .tgtCode  (tgtCode),
    .atTarget (atTarget),
    .refMv    (refMv)
  );

  assign settled = active && atTarget;

  AST_SETTLED_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    settled |-> (refMv >= MV_W'(BASE_MV) && refMv <= MV_W'(MAX_MV))); // R1

  AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (refMv == '0 && !settled)); // R7

  AST_SETTLED_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    settled |-> enable); // R9

endmodule

// File: tb/test_slew_ramp_top.sv
module test_slew_ramp_top;

  localparam int BASE_STEP = 300;
  localparam int START_STEP = 2 * BASE_STEP;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       pinMode = 1'b0;
  logic [3:0] tgtCode = '0;
  logic [1:0] slewCode = '0;
  logic [10:0] refMv;
  logic       settled;

  always #4 clk = ~clk;

  slew_ramp_top #(.BASE_STEP_UV(BASE_STEP)) i_slew_ramp_top (
    .clk(clk), .rstN(rstN), .enable(enable), .pinMode(pinMode),
    .tgtCode(tgtCode), .slewCode(slewCode), .refMv(refMv), .settled(settled)
  );

  typedef struct {
    int    expMv;
    int    expCycles;
    bit    rising;
    string req;
  } item_t;

  item_t q[$];
  bit    busy = 1'b0;
  int    nChecks = 0;
  int    nFails = 0;
  int    cyc = 0;
  int    curUv = 0;
  bit    climbDone = 1'b0;

  function automatic int benchMult(input int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 5;
      default: return 10;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: apply a command and queue the expected outcome
  task automatic cmd(input bit pin, input int code, input int slew, input string req);
    item_t it;
    int tgt, step, gap;
    @(negedge clk);
    enable   = 1'b1;
    pinMode  = pin;
    tgtCode  = 4'(code);
    slewCode = 2'(slew);
    tgt  = (850 + 50 * code) * 1000;
    step = (!climbDone || pin) ? START_STEP : BASE_STEP * benchMult(slew);
    gap  = (tgt > curUv) ? tgt - curUv : curUv - tgt;
    it.expMv     = tgt / 1000;
    it.expCycles = (gap + step - 1) / step + 1;
    it.rising    = tgt > curUv;
    it.req       = req;
    curUv     = tgt;
    climbDone = 1'b1;
    q.push_back(it);
    #1;
    wait (!busy && q.size() == 0);
  endtask

  // monitor: pop expected items and compare against the outputs
  initial begin
    forever begin
      item_t it;
      int n;
      bit over;
      wait (q.size() > 0);
      it = q.pop_front();
      busy = 1'b1;
      n = 0;
      over = 1'b0;
      do begin
        @(posedge clk);
        @(negedge clk);
        n++;
        if (it.rising && int'(refMv) > it.expMv) over = 1'b1;
      end while (!settled && n < 20000);
      check(int'(refMv) == it.expMv, {it.req, " R1"}, "settled level mV", int'(refMv), it.expMv);
      check(n == it.expCycles, {it.req, " R9"}, "cycles to settle", n, it.expCycles);
      check(!over, {it.req, " R6"}, "overshoot seen", int'(over), 0);
      busy = 1'b0;
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= 190000) begin
        nFails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(refMv == 0, "R7", "reset refMv", int'(refMv), 0);
    check(settled == 0, "R9", "reset settled", int'(settled), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    cmd(1'b0, 9, 0, "R3 startup climb ignores slew");
    cmd(1'b0, 15, 3, "R2 R4 rise at 5mV/us");
    cmd(1'b0, 0, 0, "R2 R4 fall at 0.5mV/us");
    cmd(1'b0, 3, 2, "R2 rise at 2.5mV/us");
    cmd(1'b0, 4, 1, "R2 R6 rise at 1mV/us clamped");

    // R7: disable collapses the reference within one edge
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(refMv == 0, "R7", "refMv after disable", int'(refMv), 0);
    check(settled == 0, "R7", "settled after disable", int'(settled), 0);
    tgtCode  = 4'd12;
    slewCode = 2'd3;
    repeat (5) @(negedge clk);
    check(refMv == 0, "R7", "refMv held while disabled", int'(refMv), 0);
    curUv = 0;
    climbDone = 1'b0;

    cmd(1'b0, 12, 3, "R8 R3 re-enable climb");
    cmd(1'b1, 2, 3, "R5 static mode fall");
    cmd(1'b1, 14, 0, "R5 static mode rise");

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule